// File: doc/BRIEF.md
# Received Frame Checksum Verifier

This block watches the octets of an incoming frame whose length is announced when the frame begins. It runs a 16-bit CRC over every octet, the two trailing checksum octets included. A frame is good when the remainder left at the end is zero and the announced length lies between 3 and 127. When the frame's last octet arrives, the block decides what to publish, according to the operating mode captured at frame start.

In plain receive mode, every frame ends with a frame-end pulse, and a held checksum status bit takes the frame's verdict. In auto-acknowledge receive mode, a frame with a bad checksum is discarded without a trace: no frame-end pulse, and the status bit keeps its old value. In acknowledge-wait mode, the frame is an acknowledgement. Its third octet is compared with the expected sequence number captured at frame start, and exactly one of an accept pulse or a reject pulse results.

Top module: `rx_fcs_checker`

## Requirements
- R1: After reset, `fcs_ok_o`, `frame_end_o`, `ack_ok_o` and `ack_bad_o` are all 0.
- R2: With `mode_i`=0 (plain), a frame of length 3..127 whose CRC remainder is zero gives a one-cycle `frame_end_o` in the cycle after its last octet, and `fcs_ok_o` becomes 1 in that same cycle. The CRC is x^16+x^12+x^5+1, initial value 0, bits taken LSB first, and the checksum octets are sent low octet first.
- R3: In plain mode, a frame with a nonzero remainder gives a `frame_end_o` pulse and sets `fcs_ok_o` to 0.
- R4: `fcs_ok_o` changes only in a cycle where `frame_end_o` is 1, and otherwise holds its value.
- R5: With `mode_i`=1 (auto-acknowledge), a bad frame produces no `frame_end_o` pulse and leaves `fcs_ok_o` unchanged.
- R6: In auto-acknowledge mode, a good frame gives a `frame_end_o` pulse and sets `fcs_ok_o` to 1.
- R7: A frame whose announced length is 0, 1 or 2 is bad even when its remainder is zero. A length-0 frame ends in the cycle after its start.
- R8: With `mode_i`=2 (acknowledge-wait), a good frame whose octet at index 2 equals the expected sequence number gives one `ack_ok_o` pulse, with no `frame_end_o` pulse and no change to `fcs_ok_o`.
- R9: In acknowledge-wait mode, a bad checksum or a sequence mismatch gives one `ack_bad_o` pulse and no `ack_ok_o` pulse. The two acknowledgement pulses and `frame_end_o` are never high together.
- R10: Octets offered while no frame is open are ignored. A new start during an open frame abandons the old frame and restarts the CRC.
- R11: The mode and the expected sequence number are sampled at frame start. Later changes on `mode_i` or `exp_seq_i` do not affect the frame that is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 plain, 1 auto-acknowledge, 2 acknowledge-wait (3 acts as plain) |
| exp_seq_i | input | 8 | Expected acknowledgement sequence number |
| frm_start_i | input | 1 | Opens a frame, capturing length, mode and sequence |
| frm_len_i | input | 7 | Frame length in octets, checksum included |
| byte_vld_i | input | 1 | An octet is offered on `byte_i` |
| byte_i | input | 8 | Received octet |
| frame_end_o | output | 1 | Frame-end event pulse |
| fcs_ok_o | output | 1 | Held checksum status |
| ack_ok_o | output | 1 | Acknowledgement accepted pulse |
| ack_bad_o | output | 1 | Acknowledgement rejected pulse |

## Verification
A corrupted CRC register or octet counter shows up at the ports exactly one cycle after the frame's last octet. The frame-end pulse then comes at the wrong time or is missing, or the held status bit and the acknowledgement pulses carry the wrong verdict. A status bit that drifts without an end event is visible at any idle sample. A wrongly captured mode or sequence number shows up only at the end of the frame it belongs to. For that reason, each directed frame is followed by a check of the pulse counts it produced and of the status level afterwards.

// File: rtl/rxfcs_pkg.sv
package rxfcs_pkg;

    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;

    typedef enum logic [1:0] {
        RXM_PLAIN   = 2'd0,
        RXM_AUTOACK = 2'd1,
        RXM_ACKWAIT = 2'd2,
        RXM_SPARE   = 2'd3
    } rx_mode_e;

endpackage

// File: rtl/rxfcs_crc_step.sv
module rxfcs_crc_step #(
    parameter int unsigned CRC_W = 16,
    parameter int unsigned DAT_W = 8,
    parameter logic [CRC_W-1:0] POLY = rxfcs_pkg::CRC_POLY_REFL
) (
    input  logic [CRC_W-1:0] crc_i,
    input  logic [DAT_W-1:0] dat_i,
    output logic [CRC_W-1:0] crc_o
);
    always_comb begin
        logic [CRC_W-1:0] c;
        c = crc_i;
        for (int i = 0; i < int'(DAT_W); i++) begin
            if (c[0] ^ dat_i[i]) c = (c >> 1) ^ POLY;
            else                 c = c >> 1;
        end
        crc_o = c;
    end
endmodule

// File: rtl/rxfcs_verdict.sv
module rxfcs_verdict
    import rxfcs_pkg::*;
(
    input  logic     fin_i,
    input  rx_mode_e mode_i,
    input  logic     len_ok_i,
    input  logic     crc_zero_i,
    input  logic     seq_match_i,
    output logic     irq_o,
    output logic     upd_o,
    output logic     val_o,
    output logic     ack_ok_o,
    output logic     ack_bad_o
);
    logic good;
    assign good = len_ok_i & crc_zero_i;

    always_comb begin
        irq_o     = 1'b0;
        upd_o     = 1'b0;
        val_o     = 1'b0;
        ack_ok_o  = 1'b0;
        ack_bad_o = 1'b0;
        unique case (mode_i)
            RXM_AUTOACK: begin
                irq_o = fin_i & good;
                upd_o = fin_i & good;
                val_o = 1'b1;
            end
            RXM_ACKWAIT: begin
                ack_ok_o  = fin_i & good & seq_match_i;
                ack_bad_o = fin_i & ~(good & seq_match_i);
            end
            default: begin
                irq_o = fin_i;
                upd_o = fin_i;
                val_o = good;
            end
        endcase
    end
endmodule

// File: rtl/rx_fcs_checker.sv
module rx_fcs_checker
    import rxfcs_pkg::*;
#(
    parameter int unsigned LEN_W   = 7,
    parameter int unsigned SEQ_W   = 8,
    parameter int unsigned MIN_LEN = 3,
    parameter int unsigned SEQ_IDX = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       mode_i,
    input  logic [SEQ_W-1:0] exp_seq_i,
    input  logic             frm_start_i,
    input  logic [LEN_W-1:0] frm_len_i,
    input  logic             byte_vld_i,
    input  logic [7:0]       byte_i,
    output logic             frame_end_o,
    output logic             fcs_ok_o,
    output logic             ack_ok_o,
    output logic             ack_bad_o
);
    localparam int unsigned CRC_W = 16;
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] SEQ_L = LEN_W'(SEQ_IDX);

    typedef struct packed {
        logic             active;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] cnt;
        logic [CRC_W-1:0] crc;
        rx_mode_e         mode;
        logic [SEQ_W-1:0] seq_exp;
        logic [SEQ_W-1:0] seq_got;
        logic             status;
        logic             irq;
        logic             ack_ok;
        logic             ack_bad;
    } st_t;

    st_t st_d, st_q;

    logic [CRC_W-1:0] crc_nx;
    logic             fin, len_ok, crc_zero, seq_match;
    rx_mode_e         v_mode;
    logic             v_irq, v_upd, v_val, v_ok, v_bad;

    rxfcs_crc_step #(.CRC_W(CRC_W), .DAT_W(8)) i_crc (
        .crc_i (st_q.crc),
        .dat_i (byte_i),
        .crc_o (crc_nx)
    );

    rxfcs_verdict i_verdict (
        .fin_i       (fin),
        .mode_i      (v_mode),
        .len_ok_i    (len_ok),
        .crc_zero_i  (crc_zero),
        .seq_match_i (seq_match),
        .irq_o       (v_irq),
        .upd_o       (v_upd),
        .val_o       (v_val),
        .ack_ok_o    (v_ok),
        .ack_bad_o   (v_bad)
    );

    always_comb begin
        logic [SEQ_W-1:0] seq_now;
        st_d      = st_q;
        fin       = 1'b0;
        len_ok    = 1'b0;
        crc_zero  = 1'b0;
        seq_match = 1'b0;
        v_mode    = st_q.mode;
        seq_now   = (st_q.cnt == SEQ_L) ? byte_i : st_q.seq_got;

        if (frm_start_i) begin
            st_d.active  = (frm_len_i != '0);
            st_d.len     = frm_len_i;
            st_d.cnt     = '0;
            st_d.crc     = '0;
            st_d.mode    = rx_mode_e'(mode_i);
            st_d.seq_exp = exp_seq_i;
            st_d.seq_got = '0;
            if (frm_len_i == '0) begin
                fin    = 1'b1;
                v_mode = rx_mode_e'(mode_i);
            end
        end else if (st_q.active && byte_vld_i) begin
            st_d.crc = crc_nx;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == SEQ_L) st_d.seq_got = byte_i;
            if (st_q.cnt + 1'b1 == st_q.len) begin
                st_d.active = 1'b0;
                fin         = 1'b1;
                len_ok      = (st_q.len >= MIN_L);
                crc_zero    = (crc_nx == '0);
                seq_match   = (seq_now == st_q.seq_exp);
            end
        end

        st_d.irq     = v_irq;
        st_d.ack_ok  = v_ok;
        st_d.ack_bad = v_bad;
        if (v_upd) st_d.status = v_val;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign frame_end_o = st_q.irq;
    assign fcs_ok_o    = st_q.status;
    assign ack_ok_o    = st_q.ack_ok;
    assign ack_bad_o   = st_q.ack_bad;
endmodule

// File: rtl/rxfcs_checker.sv
module rxfcs_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic byte_vld_i,
    input logic frame_end_o,
    input logic fcs_ok_o,
    input logic ack_ok_o,
    input logic ack_bad_o
);
    AST_ACK_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ack_ok_o && ack_bad_o)); // R9

    AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(fcs_ok_o) |-> frame_end_o); // R4

    AST_EVENTS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({frame_end_o, ack_ok_o, ack_bad_o})); // R9

    AST_ACCEPT_AFTER_OCTET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_ok_o |-> $past(byte_vld_i)); // R8
endmodule

bind rx_fcs_checker rxfcs_checker i_rxfcs_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_vld_i  (byte_vld_i),
    .frame_end_o (frame_end_o),
    .fcs_ok_o    (fcs_ok_o),
    .ack_ok_o    (ack_ok_o),
    .ack_bad_o   (ack_bad_o)
);

// File: tb/test_rx_fcs_checker.sv
module test_rx_fcs_checker;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [7:0] exp_seq = 8'd0;
    logic       start = 1'b0;
    logic [6:0] flen = 7'd0;
    logic       vld = 1'b0;
    logic [7:0] dat = 8'd0;
    logic       frame_end, fcs_ok, ack_ok, ack_bad;

    int n_chk = 0, n_fail = 0;
    int c_irq = 0, c_ok = 0, c_bad = 0;
    logic [7:0] fb [0:127];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_fcs_checker i_rx_fcs_checker (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .exp_seq_i(exp_seq),
        .frm_start_i(start), .frm_len_i(flen), .byte_vld_i(vld), .byte_i(dat),
        .frame_end_o(frame_end), .fcs_ok_o(fcs_ok), .ack_ok_o(ack_ok), .ack_bad_o(ack_bad)
    );

    always @(negedge clk) begin
        if (frame_end) c_irq++;
        if (ack_ok)    c_ok++;
        if (ack_bad)   c_bad++;
    end

    function automatic logic [15:0] crc_upd(logic [15:0] c, logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ 16'h8408;
            else             c = c >> 1;
        end
        return c;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // fills fb with an n-octet frame, octet 2 = seq, valid FCS in the last two
    task automatic build(int n, logic [7:0] seq);
        logic [15:0] c = 16'h0;
        for (int i = 0; i < n - 2; i++) begin
            fb[i] = (i == 2) ? seq : 8'(8'h3C + 7 * i);
            c = crc_upd(c, fb[i]);
        end
        fb[n-2] = c[7:0];
        fb[n-1] = c[15:8];
    endtask

    // sends n octets of fb; seq_late replaces exp_seq/mode inputs after start
    task automatic send(logic [1:0] m, int n, logic [7:0] seq, logic [1:0] m_late,
                        logic [7:0] seq_late);
        c_irq = 0; c_ok = 0; c_bad = 0;
        @(negedge clk);
        mode = m; exp_seq = seq; flen = 7'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0; mode = m_late; exp_seq = seq_late;
        for (int i = 0; i < n; i++) begin
            vld = 1'b1; dat = fb[i];
            @(negedge clk);
        end
        vld = 1'b0;
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        check("R1 fcs_ok", fcs_ok, 0);
        check("R1 frame_end", frame_end, 0);
        check("R1 ack pulses", ack_ok + ack_bad, 0);
    endtask

    task automatic t_plain();
        build(5, 8'h11);
        send(2'd0, 5, 8'h00, 2'd0, 8'h00);
        check("R2 irq count", c_irq, 1);
        check("R2 status", fcs_ok, 1);
        build(127, 8'h22);
        send(2'd0, 127, 8'h00, 2'd0, 8'h00);
        check("R2 len127 status", fcs_ok, 1);
        build(6, 8'h33); fb[3] ^= 8'h01;
        send(2'd0, 6, 8'h00, 2'd0, 8'h00);
        check("R3 irq count", c_irq, 1);
        check("R3 status", fcs_ok, 0);
        repeat (5) @(negedge clk);
        check("R4 idle hold", fcs_ok, 0);
    endtask

    task automatic t_autoack();
        build(8, 8'h44);
        send(2'd1, 8, 8'h00, 2'd1, 8'h00);
        check("R6 irq count", c_irq, 1);
        check("R6 status", fcs_ok, 1);
        build(8, 8'h45); fb[7] ^= 8'h80;
        send(2'd1, 8, 8'h00, 2'd1, 8'h00);
        check("R5 irq suppressed", c_irq, 0);
        check("R5 status held", fcs_ok, 1);
    endtask

    task automatic t_short();
        fb[0] = 8'h00; fb[1] = 8'h00;
        send(2'd0, 2, 8'h00, 2'd0, 8'h00);
        check("R7 len2 irq", c_irq, 1);
        check("R7 len2 status", fcs_ok, 0);
        build(3, 8'h00);
        send(2'd0, 3, 8'h00, 2'd0, 8'h00);
        check("R7 len3 status", fcs_ok, 1);
        send(2'd0, 0, 8'h00, 2'd0, 8'h00);
        check("R7 len0 irq", c_irq, 1);
        check("R7 len0 status", fcs_ok, 0);
    endtask

    task automatic t_ack();
        build(5, 8'h5A);
        send(2'd2, 5, 8'h5A, 2'd2, 8'h5A);
        check("R8 accept", c_ok, 1);
        check("R8 no reject", c_bad, 0);
        check("R8 no irq", c_irq, 0);
        check("R8 status held", fcs_ok, 0);
        send(2'd2, 5, 8'h5B, 2'd2, 8'h5B);
        check("R9 seq mismatch reject", c_bad, 1);
        check("R9 seq mismatch accept", c_ok, 0);
        fb[1] ^= 8'h04;
        send(2'd2, 5, 8'h5A, 2'd2, 8'h5A);
        check("R9 crc reject", c_bad, 1);
        check("R9 crc accept", c_ok, 0);
        build(5, 8'h07);
        send(2'd2, 5, 8'h07, 2'd0, 8'h09);
        check("R11 late change accept", c_ok, 1);
        check("R11 late change irq", c_irq, 0);
    endtask

    task automatic t_stray();
        build(5, 8'h61);
        send(2'd0, 5, 8'h00, 2'd0, 8'h00);
        c_irq = 0;
        for (int i = 0; i < 6; i++) begin
            vld = 1'b1; dat = 8'(8'hA0 + i);
            @(negedge clk);
        end
        vld = 1'b0;
        @(negedge clk); #1;
        check("R10 stray octets no irq", c_irq, 0);
        check("R10 stray octets status", fcs_ok, 1);
        @(negedge clk);
        mode = 2'd0; flen = 7'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            vld = 1'b1; dat = 8'hEE;
            @(negedge clk);
        end
        vld = 1'b0;
        build(5, 8'h62); fb[2] = 8'h99;
        send(2'd0, 5, 8'h00, 2'd0, 8'h00);
        check("R10 restart status", fcs_ok, 0);
        build(5, 8'h63);
        send(2'd0, 5, 8'h00, 2'd0, 8'h00);
        check("R10 restart irq", c_irq, 1);
        check("R10 restart good", fcs_ok, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_plain();
        t_autoack();
        t_short();
        t_ack();
        t_stray();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule